// File: doc/BRIEF.md
# Reconfigurable Switched-Capacitor Phase Driver

This block produces the gate controls for a step-down switched-capacitor power stage built from two pumping capacitors and nine switches. It takes a single fast clock and divides it into a repeating four-segment period: a charge phase, a dead gap, a discharge phase and a second dead gap. The two phase signals never overlap, and the gaps are at least `DEAD_CYC` cycles long. The phase lengths and the gap lengths are parameters.

A two-bit select picks the conversion ratio: one third, one half or two thirds. For each ratio, every switch is bound to the charge phase, to the discharge phase, or held permanently off. The ratio is captured only when a new charge phase is about to begin. At that moment both phases are low, so a change of select never reshapes a phase that is already running.

A gate-enable input lets an outside regulation controller start and stop switching. When enable drops, the phase in progress runs to its full length, and after that nothing switches until enable returns. Switching always restarts with a dead gap followed by a charge phase.

Top module: `sc_phase_driver`

## Requirements
- R1: While reset is high, and afterwards for as long as `gate_en` stays low, `phase_chg`, `phase_dis` and all of `sw_gate` are 0.
- R2: `phase_chg` and `phase_dis` are never 1 together, and every high run of either signal lasts exactly `ON_CYC` cycles.
- R3: Between the fall of one phase and the rise of the other, both phases stay low for at least `DEAD_CYC` cycles.
- R4: With `gain_sel` = 00 (ratio one third), `sw_gate` = 0x0A9 during the charge phase (switches 1, 4, 6, 8, on bits 0, 3, 5, 7) and 0x144 during the discharge phase (switches 3, 7, 9). Switches 2 and 5 stay off.
- R5: With `gain_sel` = 01 (ratio one half), `sw_gate` = 0x0BB during the charge phase (switches 1, 2, 4, 5, 6, 8) and 0x044 during the discharge phase (switches 3, 7). Switch 9 stays off.
- R6: With `gain_sel` = 10 (ratio two thirds), `sw_gate` = 0x1B3 during the charge phase (switches 1, 2, 5, 6, 8, 9) and 0x004 during the discharge phase (switch 3). Switches 4 and 7 stay off.
- R7: `gain_sel` = 11 is illegal and yields exactly the one-third patterns of R4.
- R8: Whenever both phases are low, `sw_gate` is 0.
- R9: `gain_sel` is sampled only at the start of a charge phase. A change made during a period first shows at the next charge phase, and `sw_gate` holds constant during each phase.
- R10: After `gate_en` falls, the phase in progress completes with its full length. No further phase starts until `gate_en` is 1 again.
- R11: After `gate_en` rises from the idle state, the first phase is the charge phase. It rises on the `DEAD_CYC`+1-th clock edge that samples `gate_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, shared with the regulation controller |
| rst | input | 1 | Synchronous active-high reset |
| gain_sel | input | 2 | Ratio select: 00 one third, 01 one half, 10 two thirds, 11 treated as 00 |
| gate_en | input | 1 | 1 lets switching run; 0 stops it after the current phase |
| sw_gate | output | 9 | Switch gate controls, bit i drives switch i+1 |
| phase_chg | output | 1 | Charge phase, registered |
| phase_dis | output | 1 | Discharge phase, registered |

## Verification
A segment counter or state that goes wrong shows at the phase outputs within one period, as a wrong run length, an overlap or a short gap. A wrong or stale captured ratio first shows at the next charge-phase rise, as a wrong switch pattern. A scoreboard therefore checks each phase onset against a queued expected pattern and rejects any onset it did not expect. A per-cycle monitor times every run and every gap. A mid-period ratio change and an enable drop during the charge phase test the boundary-only capture and the clean stop.

// File: rtl/sc_phase_pkg.sv
package sc_phase_pkg;

  localparam int NUM_SW = 9;

  typedef enum logic [1:0] {
    GR_THIRD      = 2'd0,
    GR_HALF       = 2'd1,
    GR_TWO_THIRDS = 2'd2
  } gain_t;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_P1  = 2'd1,
    DRV_P2  = 2'd2
  } drive_t;

  typedef enum logic [2:0] {
    SEG_IDLE = 3'd0,
    SEG_LEAD = 3'd1,
    SEG_P1   = 3'd2,
    SEG_MID  = 3'd3,
    SEG_P2   = 3'd4
  } seg_t;

  // Illegal code 11 folds onto the one-third ratio.
  function automatic gain_t decode_sel(input logic [1:0] sel);
    case (sel)
      2'd1:    return GR_HALF;
      2'd2:    return GR_TWO_THIRDS;
      default: return GR_THIRD;
    endcase
  endfunction

  // Role of switch idx (0-based) under a given ratio.
  function automatic drive_t switch_role(input gain_t g, input int unsigned idx);
    drive_t r;
    case (idx)
      0, 5, 7: r = DRV_P1;
      2:       r = DRV_P2;
      1, 4:    r = (g == GR_THIRD) ? DRV_OFF : DRV_P1;
      3:       r = (g == GR_TWO_THIRDS) ? DRV_OFF : DRV_P1;
      6:       r = (g == GR_TWO_THIRDS) ? DRV_OFF : DRV_P2;
      8:       r = (g == GR_THIRD) ? DRV_P2 :
                   (g == GR_HALF)  ? DRV_OFF : DRV_P1;
      default: r = DRV_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sc_phase_seq.sv
module sc_phase_seq
  import sc_phase_pkg::*;
#(
  parameter int ON_CYC   = 2,
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  output logic nxt_p1,
  output logic nxt_p2,
  output logic load_gain
);

  localparam int MAX_LEN = (ON_CYC > DEAD_CYC) ? ON_CYC : DEAD_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] ON_LAST   = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);

  seg_t             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seg_end;

  always_comb begin
    case (seg_q)
      SEG_P1, SEG_P2:     seg_end = (cnt_q == ON_LAST);
      SEG_LEAD, SEG_MID:  seg_end = (cnt_q == DEAD_LAST);
      default:            seg_end = 1'b1;
    endcase
  end

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q + 1'b1;
    if (seg_end) begin
      cnt_d = '0;
      if (!gate_en) begin
        seg_d = SEG_IDLE;
      end else begin
        case (seg_q)
          SEG_IDLE: seg_d = SEG_LEAD;
          SEG_LEAD: seg_d = SEG_P1;
          SEG_P1:   seg_d = SEG_MID;
          SEG_MID:  seg_d = SEG_P2;
          default:  seg_d = SEG_LEAD;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_IDLE;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  assign nxt_p1    = (seg_d == SEG_P1);
  assign nxt_p2    = (seg_d == SEG_P2);
  assign load_gain = seg_end && gate_en && (seg_q == SEG_LEAD);

endmodule

// File: rtl/sc_gain_hold.sv
module sc_gain_hold
  import sc_phase_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel,
  output gain_t      gain_nxt
);

  gain_t gain_q;

  assign gain_nxt = load ? decode_sel(sel) : gain_q;

  always_ff @(posedge clk) begin
    if (rst) gain_q <= GR_THIRD;
    else     gain_q <= gain_nxt;
  end

endmodule

// File: rtl/sc_switch_map.sv
module sc_switch_map
  import sc_phase_pkg::*;
(
  input  gain_t             gain,
  input  logic              p1,
  input  logic              p2,
  output logic [NUM_SW-1:0] sw
);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    drive_t role;
    assign role  = switch_role(gain, i);
    assign sw[i] = ((role == DRV_P1) && p1) || ((role == DRV_P2) && p2);
  end

endmodule

// File: rtl/sc_phase_driver.sv
module sc_phase_driver
  import sc_phase_pkg::*;
#(
  parameter int ON_CYC   = 2,
  parameter int DEAD_CYC = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          gain_sel,
  input  logic                gate_en,
  output logic [NUM_SW-1:0]   sw_gate,
  output logic                phase_chg,
  output logic                phase_dis
);

  logic              nxt_p1, nxt_p2, load_gain;
  gain_t             gain_nxt;
  logic [NUM_SW-1:0] sw_d;

  sc_phase_seq #(
    .ON_CYC   (ON_CYC),
    .DEAD_CYC (DEAD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .gate_en   (gate_en),
    .nxt_p1    (nxt_p1),
    .nxt_p2    (nxt_p2),
    .load_gain (load_gain)
  );

  sc_gain_hold u_gain (
    .clk      (clk),
    .rst      (rst),
    .load     (load_gain),
    .sel      (gain_sel),
    .gain_nxt (gain_nxt)
  );

  sc_switch_map u_map (
    .gain (gain_nxt),
    .p1   (nxt_p1),
    .p2   (nxt_p2),
    .sw   (sw_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_gate   <= '0;
      phase_chg <= 1'b0;
      phase_dis <= 1'b0;
    end else begin
      sw_gate   <= sw_d;
      phase_chg <= nxt_p1;
      phase_dis <= nxt_p2;
    end
  end

endmodule

// File: rtl/sc_phase_driver_chk.sv
module sc_phase_driver_chk (
  input logic       clk,
  input logic       rst,
  input logic       gate_en,
  input logic [8:0] sw_gate,
  input logic       phase_chg,
  input logic       phase_dis
);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(phase_chg && phase_dis));

  assert_gap_after_chg_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_chg) |-> !phase_dis);

  assert_gap_after_dis_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_dis) |-> !phase_chg);

  assert_idle_switches_low_R8: assert property (@(posedge clk) disable iff (rst)
    (!phase_chg && !phase_dis) |-> (sw_gate == 9'd0));

  assert_chg_pattern_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_chg && $past(phase_chg)) |-> $stable(sw_gate));

  assert_dis_pattern_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_dis && $past(phase_dis)) |-> $stable(sw_gate));

  assert_chg_count_R5: assert property (@(posedge clk) disable iff (rst)
    phase_chg |-> ($countones(sw_gate) == 4 || $countones(sw_gate) == 6));

  assert_dis_count_R6: assert property (@(posedge clk) disable iff (rst)
    phase_dis |-> ($countones(sw_gate) >= 1 && $countones(sw_gate) <= 3));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && !phase_chg && !phase_dis) |=> (!phase_chg && !phase_dis));

endmodule

bind sc_phase_driver sc_phase_driver_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate_en   (gate_en),
  .sw_gate   (sw_gate),
  .phase_chg (phase_chg),
  .phase_dis (phase_dis)
);

// File: tb/tb_sc_phase_driver.sv
module tb_sc_phase_driver;

  localparam int ON_C   = 2;
  localparam int DEAD_C = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] gain_sel = 2'd0;
  logic       gate_en = 1'b0;
  logic [8:0] sw_gate;
  logic       phase_chg, phase_dis;

  int checks = 0;
  int errors = 0;
  int n_chg = 0;
  int n_dis = 0;

  logic [8:0] exp_chg[$];
  logic [8:0] exp_dis[$];
  string      tag_chg[$];
  string      tag_dis[$];

  always #4 clk = ~clk;

  sc_phase_driver #(.ON_CYC(ON_C), .DEAD_CYC(DEAD_C)) dut (
    .clk       (clk),
    .rst       (rst),
    .gain_sel  (gain_sel),
    .gate_en   (gate_en),
    .sw_gate   (sw_gate),
    .phase_chg (phase_chg),
    .phase_dis (phase_dis)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected patterns straight from R4..R7.
  function automatic logic [8:0] pat_chg(input logic [1:0] s);
    case (s)
      2'd1:    return 9'h0BB;
      2'd2:    return 9'h1B3;
      default: return 9'h0A9;
    endcase
  endfunction

  function automatic logic [8:0] pat_dis(input logic [1:0] s);
    case (s)
      2'd1:    return 9'h044;
      2'd2:    return 9'h004;
      default: return 9'h144;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'd1:    return "R5";
      2'd2:    return "R6";
      2'd3:    return "R7";
      default: return "R4";
    endcase
  endfunction

  // Monitor: scoreboard pops at each phase onset, plus timing checks.
  logic [8:0] prev_sw;
  logic prev_a, prev_b;
  int   run_a, run_b, low_cnt;

  always @(negedge clk) begin
    if (rst) begin
      chk(!phase_chg && !phase_dis && sw_gate == 0, "R1", "outputs in reset",
          {phase_chg, phase_dis, sw_gate}, 0);
      prev_a = 0; prev_b = 0; prev_sw = 0; run_a = 0; run_b = 0; low_cnt = 0;
    end else begin
      if (phase_chg && phase_dis)
        chk(0, "R2", "phases overlap", 3, 0);
      if (!phase_chg && !phase_dis && sw_gate != 0)
        chk(0, "R8", "switch on outside phase", sw_gate, 0);
      if ((phase_chg && prev_a) || (phase_dis && prev_b))
        if (sw_gate != prev_sw) chk(0, "R9", "pattern changed in phase", sw_gate, prev_sw);
      if (phase_chg && !prev_a) begin
        chk(low_cnt >= DEAD_C, "R3", "gap before charge", low_cnt, DEAD_C);
        n_chg++;
        if (exp_chg.size() == 0) chk(0, "R10", "unexpected charge onset", sw_gate, 0);
        else begin
          logic [8:0] e; string t;
          e = exp_chg.pop_front(); t = tag_chg.pop_front();
          chk(sw_gate == e, t, "charge pattern", sw_gate, e);
        end
      end
      if (phase_dis && !prev_b) begin
        chk(low_cnt >= DEAD_C, "R3", "gap before discharge", low_cnt, DEAD_C);
        n_dis++;
        if (exp_dis.size() == 0) chk(0, "R10", "unexpected discharge onset", sw_gate, 0);
        else begin
          logic [8:0] e; string t;
          e = exp_dis.pop_front(); t = tag_dis.pop_front();
          chk(sw_gate == e, t, "discharge pattern", sw_gate, e);
        end
      end
      if (prev_a && !phase_chg) chk(run_a == ON_C, "R2", "charge length", run_a, ON_C);
      if (prev_b && !phase_dis) chk(run_b == ON_C, "R2", "discharge length", run_b, ON_C);
      run_a   = phase_chg ? run_a + 1 : 0;
      run_b   = phase_dis ? run_b + 1 : 0;
      low_cnt = (phase_chg || phase_dis) ? 0 : low_cnt + 1;
      prev_a = phase_chg; prev_b = phase_dis; prev_sw = sw_gate;
    end
  end

  task automatic push_period(input logic [1:0] s);
    exp_chg.push_back(pat_chg(s)); tag_chg.push_back(req_of(s));
    exp_dis.push_back(pat_dis(s)); tag_dis.push_back(req_of(s));
  endtask

  task automatic wait_dis(input int target);
    do @(posedge clk); while (n_dis < target);
    @(negedge clk);
  endtask

  task automatic settle_idle();
    repeat (2 * (ON_C + DEAD_C) + 6) @(negedge clk);
    chk(!phase_chg && !phase_dis && sw_gate == 0, "R10", "quiet after disable",
        {phase_chg, phase_dis, sw_gate}, 0);
  endtask

  // Run n full periods at one select, measuring start latency.
  task automatic run_sel(input logic [1:0] s, input int n);
    int start, lat;
    @(negedge clk);
    gain_sel = s;
    for (int i = 0; i < n; i++) push_period(s);
    start = n_dis;
    gate_en = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!phase_chg && lat < 20);
    chk(lat == DEAD_C + 1, "R11", "charge start latency", lat, DEAD_C + 1);
    wait_dis(start + n);
    gate_en = 1'b0;
    settle_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!phase_chg && !phase_dis && sw_gate == 0, "R1", "idle with enable low",
        {phase_chg, phase_dis, sw_gate}, 0);

    run_sel(2'd0, 3);
    run_sel(2'd1, 3);
    run_sel(2'd2, 3);
    run_sel(2'd3, 2);

    // R9: change select mid charge phase; takes effect next period.
    begin
      int s0;
      @(negedge clk);
      gain_sel = 2'd1;
      push_period(2'd1);
      exp_chg.push_back(pat_chg(2'd2)); tag_chg.push_back("R9");
      exp_dis.push_back(pat_dis(2'd2)); tag_dis.push_back("R9");
      s0 = n_chg;
      gate_en = 1'b1;
      do @(posedge clk); while (n_chg < s0 + 1);
      @(negedge clk);
      gain_sel = 2'd2;
      wait_dis(n_dis + 2 - ((phase_dis) ? 1 : 0));
      gate_en = 1'b0;
      settle_idle();
    end

    // R10: drop enable during charge; it completes, no discharge follows.
    begin
      int s0, d0;
      @(negedge clk);
      gain_sel = 2'd0;
      exp_chg.push_back(pat_chg(2'd0)); tag_chg.push_back("R10");
      s0 = n_chg; d0 = n_dis;
      gate_en = 1'b1;
      do @(posedge clk); while (n_chg < s0 + 1);
      @(negedge clk);
      gate_en = 1'b0;
      settle_idle();
      chk(n_dis == d0, "R10", "discharge count after stop", n_dis, d0);
    end

    // R11: restart after the stop begins again with a charge phase.
    run_sel(2'd1, 1);

    chk(exp_chg.size() == 0, "R2", "charge onsets missing", exp_chg.size(), 0);
    chk(exp_dis.size() == 0, "R2", "discharge onsets missing", exp_dis.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule